// File: doc/BRIEF.md
# Programming-Mode Word Address Counter and Map Decoder

This block tracks the word address used while a small microcontroller is held in its serial programming mode. It owns a 14-bit address that clears on reset or mode entry and advances by one on each step command. A load-configuration command moves it to the start of the configuration half. The top address bit acts as a sticky region flag. Once it is set, stepping wraps inside the configuration half, and only a reset or a fresh mode entry brings the counter back to user space.

Each address is decoded for two arrays. The first is a 1K-word user flash, which every user address aliases onto through its low ten bits. The second is a 32-word configuration array, which every configuration address aliases onto through its low five bits. Inside that array only the four identifier words at offsets 0 to 3 and the configuration word at offset 7 are usable. All other offsets are reserved.

Array read data flows through a valid/ready stage with no storage. The downstream ready is passed straight back to the array side, and valid passes forward in the same cycle, so a stall holds the array. A word that is read from a reserved location comes out as zero. A word that is read from the user array while code protection is on also comes out as zero. The gating uses the address that is held in the cycle when the transfer completes. Write requests become an enable for exactly one array, or no enable at all when the location is reserved.

Top module: `pgm_addr_unit`

## Requirements
- R1: An asynchronous active-low reset, or a `mode_enter` pulse, sets the address to 0x0000 with the configuration region flag cleared.
- R2: In the user region, a step adds one to the address and 0x1FFF wraps to 0x0000.
- R3: `load_cfg` sets the address to 0x2000 and sets the region flag. In the configuration region a step adds one and 0x3FFF wraps to 0x2000.
- R4: The region flag (address bit 13) stays set through any number of steps. The command priority is `mode_enter`, then `load_cfg`, then `step`.
- R5: In the user region `user_sel_o` is 1 and `user_idx_o` equals address bits 9:0, so 0x0400 maps to index 0.
- R6: In the configuration region `cfg_sel_o` is 1 and `cfg_idx_o` equals address bits 4:0, so 0x2020 maps to index 0.
- R7: `reserved_o` is 1 exactly when the address is in the configuration region and bits 4:0 are in the range 4 to 6 or 8 to 31. It is never 1 in the user region.
- R8: While `reserved_o` is 1, `rd_data_o` is 0x0000.
- R9: When `protect` is 1, user-region reads give 0x0000. Configuration reads at offsets 0 to 3 and 7 pass `arr_data_i` through unchanged whatever the value of `protect`.
- R10: `user_wr_en_o` equals `wr_req_i` in the user region. `cfg_wr_en_o` equals `wr_req_i` in the configuration region at a usable offset. A write to a reserved location raises neither enable.
- R11: `rd_valid_o` follows `arr_valid_i` and `arr_ready_o` follows `rd_ready_i` in the same cycle. A transfer happens when valid and ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_enter | input | 1 | Programming-mode entry; clears the address |
| load_cfg | input | 1 | Jump to 0x2000 and set the region flag |
| step | input | 1 | Advance the address by one |
| protect | input | 1 | Code protection active |
| addr_o | output | 14 | Current word address |
| cfg_region_o | output | 1 | Sticky configuration region flag |
| user_sel_o | output | 1 | Address selects the user array |
| cfg_sel_o | output | 1 | Address selects the configuration array |
| reserved_o | output | 1 | Address is a reserved configuration location |
| user_idx_o | output | 10 | User array word index |
| cfg_idx_o | output | 5 | Configuration array word index |
| wr_req_i | input | 1 | Write request for the current address |
| user_wr_en_o | output | 1 | Write enable to the user array |
| cfg_wr_en_o | output | 1 | Write enable to the configuration array |
| arr_valid_i | input | 1 | Array read data valid |
| arr_ready_o | output | 1 | Ready back to the array |
| arr_data_i | input | 14 | Array read word |
| rd_valid_o | output | 1 | Outgoing read word valid |
| rd_ready_i | input | 1 | Downstream ready |
| rd_data_o | output | 14 | Outgoing read word, after blanking |

## Verification
The bench walks every one of the 8192 user addresses and then wraps. A counter that carried into bit 13 would leave user space at this point instead of returning to 0x0000. It then walks the full configuration half and past its wrap. A counter that dropped the sticky flag would fall back to 0x0000 or to 0x1FFF+1 behaviour. This walk also exposes decoders that alias on the wrong bits at 0x0400 or 0x2020, and a reserved mask that is shifted by one offset. Protection is toggled while the identifier words and the configuration word are read, which catches a design that blanks every read rather than only user reads. Overlapping commands check the priority order, and a reset or mode entry from deep inside the configuration half checks the only way back to user space.

// File: rtl/pgm_addr_pkg.sv
package pgm_addr_pkg;
  // Default geometry of the programming address space.
  localparam int ADDR_W       = 14;
  localparam int DATA_W       = 14;
  localparam int USER_IDX_W   = 10;
  localparam int CFG_IDX_W    = 5;
  localparam int ID_WORDS     = 4;
  localparam int CFG_WORD_OFF = 7;

  // Result of decoding one address.
  typedef struct packed {
    logic                  sel_user;
    logic                  sel_cfg;
    logic                  reserved;
    logic [USER_IDX_W-1:0] user_idx;
    logic [CFG_IDX_W-1:0]  cfg_idx;
  } map_t;

  // Command selected for a cycle, highest priority first.
  typedef enum logic [1:0] {
    CMD_ENTER = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_STEP  = 2'd2,
    CMD_HOLD  = 2'd3
  } cmd_e;
endpackage

// File: rtl/pgm_addr_counter.sv
module pgm_addr_counter
  import pgm_addr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_enter,
  input  logic          load_cfg,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          cfg_region
);
  localparam int OW = AW - 1;

  logic [OW-1:0] offs_q, offs_d;
  logic          cfg_q, cfg_d;
  cmd_e          cmd;

  // Priority: mode entry, then load, then step.
  always_comb begin
    if (mode_enter)    cmd = CMD_ENTER;
    else if (load_cfg) cmd = CMD_LOAD;
    else if (step)     cmd = CMD_STEP;
    else               cmd = CMD_HOLD;
  end

  // The offset is one bit narrower than the address, so it wraps on its
  // own inside whichever half the sticky flag selects.
  always_comb begin
    offs_d = offs_q;
    cfg_d  = cfg_q;
    unique case (cmd)
      CMD_ENTER: begin offs_d = '0; cfg_d = 1'b0; end
      CMD_LOAD:  begin offs_d = '0; cfg_d = 1'b1; end
      CMD_STEP:  offs_d = offs_q + OW'(1);
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '0;
      cfg_q  <= 1'b0;
    end else begin
      offs_q <= offs_d;
      cfg_q  <= cfg_d;
    end
  end

  assign addr       = {cfg_q, offs_q};
  assign cfg_region = cfg_q;
endmodule

// File: rtl/pgm_addr_decode.sv
module pgm_addr_decode
  import pgm_addr_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int UW       = USER_IDX_W,
  parameter int CW       = CFG_IDX_W,
  parameter int N_ID     = ID_WORDS,
  parameter int WORD_OFF = CFG_WORD_OFF
) (
  input  logic [AW-1:0] addr,
  input  logic          cfg_region,
  output map_t          map
);
  localparam int CFG_DEPTH = 1 << CW;

  logic [CFG_DEPTH-1:0] usable;
  logic [CW-1:0]        coff;

  // One usable bit per implemented configuration offset.
  for (genvar g = 0; g < CFG_DEPTH; g++) begin : g_usable
    assign usable[g] = (g < N_ID) || (g == WORD_OFF);
  end

  assign coff = addr[CW-1:0];

  always_comb begin
    map          = '0;
    map.sel_user = ~cfg_region;
    map.sel_cfg  = cfg_region;
    map.user_idx = addr[UW-1:0];
    map.cfg_idx  = coff;
    map.reserved = cfg_region & ~usable[coff];
  end
endmodule

// File: rtl/pgm_read_gate.sv
module pgm_read_gate #(
  parameter int DW = pgm_addr_pkg::DATA_W
) (
  input  logic          blank,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  // Zero-storage stage: back-pressure passes straight through.
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = blank ? '0 : in_data;
endmodule

// File: rtl/pgm_write_steer.sv
module pgm_write_steer (
  input  logic wr_req,
  input  logic sel_user,
  input  logic sel_cfg,
  input  logic reserved,
  output logic user_wr_en,
  output logic cfg_wr_en
);
  assign user_wr_en = wr_req & sel_user;
  assign cfg_wr_en  = wr_req & sel_cfg & ~reserved;
endmodule

// File: rtl/pgm_addr_unit.sv
module pgm_addr_unit
  import pgm_addr_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int DW       = DATA_W,
  parameter int UW       = USER_IDX_W,
  parameter int CW       = CFG_IDX_W,
  parameter int N_ID     = ID_WORDS,
  parameter int WORD_OFF = CFG_WORD_OFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_enter,
  input  logic          load_cfg,
  input  logic          step,
  input  logic          protect,
  output logic [AW-1:0] addr_o,
  output logic          cfg_region_o,
  output logic          user_sel_o,
  output logic          cfg_sel_o,
  output logic          reserved_o,
  output logic [UW-1:0] user_idx_o,
  output logic [CW-1:0] cfg_idx_o,
  input  logic          wr_req_i,
  output logic          user_wr_en_o,
  output logic          cfg_wr_en_o,
  input  logic          arr_valid_i,
  output logic          arr_ready_o,
  input  logic [DW-1:0] arr_data_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0] addr;
  logic          cfg_region;
  map_t          map;
  logic          blank;

  pgm_addr_counter #(.AW(AW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_enter (mode_enter),
    .load_cfg   (load_cfg),
    .step       (step),
    .addr       (addr),
    .cfg_region (cfg_region)
  );

  pgm_addr_decode #(
    .AW(AW), .UW(UW), .CW(CW), .N_ID(N_ID), .WORD_OFF(WORD_OFF)
  ) u_dec (
    .addr       (addr),
    .cfg_region (cfg_region),
    .map        (map)
  );

  // Reserved words never read out, and protection hides only the user array.
  assign blank = map.reserved | (map.sel_user & protect);

  pgm_read_gate #(.DW(DW)) u_rd (
    .blank     (blank),
    .in_valid  (arr_valid_i),
    .in_ready  (arr_ready_o),
    .in_data   (arr_data_i),
    .out_valid (rd_valid_o),
    .out_ready (rd_ready_i),
    .out_data  (rd_data_o)
  );

  pgm_write_steer u_wr (
    .wr_req     (wr_req_i),
    .sel_user   (map.sel_user),
    .sel_cfg    (map.sel_cfg),
    .reserved   (map.reserved),
    .user_wr_en (user_wr_en_o),
    .cfg_wr_en  (cfg_wr_en_o)
  );

  assign addr_o       = addr;
  assign cfg_region_o = cfg_region;
  assign user_sel_o   = map.sel_user;
  assign cfg_sel_o    = map.sel_cfg;
  assign reserved_o   = map.reserved;
  assign user_idx_o   = map.user_idx;
  assign cfg_idx_o    = map.cfg_idx;
endmodule

// File: rtl/pgm_addr_checker.sv
module pgm_addr_checker #(
  parameter int AW = 14,
  parameter int DW = 14,
  parameter int UW = 10,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_enter,
  input logic          load_cfg,
  input logic          step,
  input logic          protect,
  input logic [AW-1:0] addr_o,
  input logic          cfg_region_o,
  input logic          user_sel_o,
  input logic          cfg_sel_o,
  input logic          reserved_o,
  input logic [UW-1:0] user_idx_o,
  input logic [CW-1:0] cfg_idx_o,
  input logic          wr_req_i,
  input logic          user_wr_en_o,
  input logic          cfg_wr_en_o,
  input logic          arr_valid_i,
  input logic          arr_ready_o,
  input logic [DW-1:0] arr_data_i,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic [DW-1:0] rd_data_o
);
  localparam logic [AW-1:0] USER_TOP = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] CFG_TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] CFG_BASE = {1'b1, {(AW-1){1'b0}}};

  assert_enter_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_enter |=> (addr_o == '0) && !cfg_region_o);

  assert_user_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode_enter && !load_cfg && addr_o == USER_TOP) |=> addr_o == '0);

  assert_cfg_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode_enter && !load_cfg && addr_o == CFG_TOP) |=> addr_o == CFG_BASE);

  assert_load_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cfg && !mode_enter) |=> addr_o == CFG_BASE);

  assert_sticky_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_region_o && !mode_enter) |=> cfg_region_o);

  assert_user_never_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    user_sel_o |-> !reserved_o);

  assert_reserved_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reserved_o && rd_valid_o) |-> rd_data_o == '0);

  assert_protected_user_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (user_sel_o && protect && rd_valid_o) |-> rd_data_o == '0);

  assert_no_reserved_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_o |-> !(user_wr_en_o || cfg_wr_en_o));

  assert_one_write_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({user_wr_en_o, cfg_wr_en_o}));

  assert_stall_holds_array_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid_i && !rd_ready_i) |-> (rd_valid_o && !arr_ready_o));
endmodule

bind pgm_addr_unit pgm_addr_checker #(
  .AW(AW), .DW(DW), .UW(UW), .CW(CW)
) i_pgm_addr_checker (.*);

// File: tb/test_pgm_addr_unit.sv
module test_pgm_addr_unit;
  localparam int MAX_CYCLES = 60000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_enter = 1'b0, load_cfg = 1'b0, step = 1'b0;
  logic        protect, wr_req_i, arr_valid_i, rd_ready_i;
  logic [13:0] arr_data_i;
  logic [13:0] addr_o, rd_data_o;
  logic        cfg_region_o, user_sel_o, cfg_sel_o, reserved_o;
  logic [9:0]  user_idx_o;
  logic [4:0]  cfg_idx_o;
  logic        user_wr_en_o, cfg_wr_en_o, arr_ready_o, rd_valid_o;

  logic [13:0] exp_addr = '0;
  logic        exp_cfg  = 1'b0;
  logic        force_prot = 1'b0;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  // Side inputs vary with the expected address so every pattern is covered.
  assign protect     = force_prot | (exp_addr[0] ^ exp_addr[6]);
  assign wr_req_i    = exp_addr[1] ^ exp_addr[8];
  assign arr_valid_i = ~exp_addr[2];
  assign rd_ready_i  = exp_addr[3] ^ exp_addr[5];
  assign arr_data_i  = exp_addr ^ 14'h2A5C;

  pgm_addr_unit i_pgm_addr_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, exp_addr, act, exp);
    end
  endtask

  task automatic check_all();
    logic        res;
    logic [13:0] erd;
    logic [4:0]  off;
    off = exp_addr[4:0];
    res = exp_cfg && !((off < 5'd4) || (off == 5'd7));
    erd = (res || (!exp_cfg && protect)) ? 14'h0 : arr_data_i;
    chk(addr_o == exp_addr, exp_cfg ? "R3 address" : "R2 address", 32'(addr_o), 32'(exp_addr));
    chk(cfg_region_o == exp_cfg, "R4 region flag", 32'(cfg_region_o), 32'(exp_cfg));
    chk(user_sel_o == !exp_cfg && cfg_sel_o == exp_cfg, "R5/R6 selects",
        32'({user_sel_o, cfg_sel_o}), 32'({!exp_cfg, exp_cfg}));
    if (!exp_cfg) chk(user_idx_o == exp_addr[9:0], "R5 user index", 32'(user_idx_o), 32'(exp_addr[9:0]));
    else          chk(cfg_idx_o == off, "R6 cfg index", 32'(cfg_idx_o), 32'(off));
    chk(reserved_o == res, "R7 reserved", 32'(reserved_o), 32'(res));
    chk(rd_data_o == erd, res ? "R8 read data" : "R9 read data", 32'(rd_data_o), 32'(erd));
    chk(user_wr_en_o == (wr_req_i && !exp_cfg) && cfg_wr_en_o == (wr_req_i && exp_cfg && !res),
        "R10 write enables", 32'({user_wr_en_o, cfg_wr_en_o}),
        32'({wr_req_i && !exp_cfg, wr_req_i && exp_cfg && !res}));
    chk(rd_valid_o == arr_valid_i && arr_ready_o == rd_ready_i, "R11 handshake",
        32'({rd_valid_o, arr_ready_o}), 32'({arr_valid_i, rd_ready_i}));
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Run n steps with step held high, checking after each edge.
  task automatic run_steps(input int n);
    step = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exp_addr = {exp_cfg, exp_addr[12:0] + 13'd1};
      check_all();
      if (!exp_cfg && exp_addr == 14'h0400)
        chk(user_idx_o == 10'd0, "R5 alias at 0x0400", 32'(user_idx_o), 0);
      if (exp_cfg && exp_addr == 14'h2020)
        chk(cfg_idx_o == 5'd0, "R6 alias at 0x2020", 32'(cfg_idx_o), 0);
      if (exp_addr == 14'h0000 && i > 0)
        chk(1'b1, "R2 user wrap reached", 0, 0);
    end
    step = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_all();                       // R1 state while held in reset
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    chk(addr_o == 14'h0 && !cfg_region_o, "R1 reset state", 32'(addr_o), 0);

    // R2: full user half, through the wrap back to zero.
    run_steps(8192 + 3);

    // R9: identifier words and configuration word unaffected by protection.
    force_prot = 1'b1;
    load_cfg = 1'b1;
    @(negedge clk);
    load_cfg = 1'b0;
    exp_addr = 14'h2000; exp_cfg = 1'b1;
    check_all();
    chk(addr_o == 14'h2000 && cfg_region_o, "R3 load_cfg", 32'(addr_o), 32'h2000);
    run_steps(8);
    force_prot = 1'b0;

    // R3/R4: whole configuration half, through its wrap, flag stays set.
    run_steps(8192 + 40);

    // R4 priority: load beats step.
    load_cfg = 1'b1; step = 1'b1;
    @(negedge clk);
    load_cfg = 1'b0; step = 1'b0;
    exp_addr = 14'h2000;
    check_all();
    chk(addr_o == 14'h2000, "R4 load over step", 32'(addr_o), 32'h2000);
    run_steps(5);

    // R4 priority: mode entry beats load; R1 mode entry clears.
    mode_enter = 1'b1; load_cfg = 1'b1; step = 1'b1;
    @(negedge clk);
    mode_enter = 1'b0; load_cfg = 1'b0; step = 1'b0;
    exp_addr = 14'h0000; exp_cfg = 1'b0;
    check_all();
    chk(addr_o == 14'h0 && !cfg_region_o, "R1 mode entry clears", 32'(addr_o), 0);
    run_steps(20);

    // R1: asynchronous reset from deep inside the configuration half.
    load_cfg = 1'b1;
    @(negedge clk);
    load_cfg = 1'b0;
    exp_addr = 14'h2000; exp_cfg = 1'b1;
    run_steps(37);
    #1 rst_n = 1'b0;
    #1;
    exp_addr = 14'h0000; exp_cfg = 1'b0;
    chk(addr_o == 14'h0 && !cfg_region_o, "R1 async reset", 32'(addr_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    done = 1'b1;
    report();
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", MAX_CYCLES, 0);
      report();
    end
  end
endmodule